// File: doc/BRIEF.md
# Serial Frame Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial frames on a single line and places them in a small read buffer. Frames carry one low start bit, eight data bits least significant first, an optional ninth bit, and one high stop bit. The line is sampled on a tick that runs at sixteen times the bit rate. The tick comes from outside the block. When nine-bit frames and address filtering are both on, only frames whose ninth bit is 1 are kept. This lets a node on a shared line ignore traffic until it is addressed. When filtering is off, every frame is kept, and the ninth bit is passed out for parity or any other use decided downstream.

The buffer holds two frames. Each entry keeps its own stop-bit error, so the framing flag always describes the frame currently shown at the outputs. A frame that completes while both entries are full is dropped and sets a sticky overrun flag. An idle output shows whether a frame is in flight.

A wake monitor can be armed with a one-cycle pulse. While it is armed, reception is suspended. The monitor raises a one-cycle interrupt on a falling line edge and disarms itself on the next rising edge. Dropping the port enable returns the whole block to its reset state.

Top module: `uart_rx_addr`

## Requirements
- R1: With `cfg_nine`=0, a frame of a low start bit, 8 data bits (LSB first) and a stop bit is stored. Its byte appears on `rd_data`, `rd_bit9` reads 0, and `data_ready` is 1 until `rd_pop` removes it.
- R2: With `cfg_nine`=1, a ninth bit follows the 8 data bits and appears on `rd_bit9` alongside the byte.
- R3: With `cfg_nine`=1 and `cfg_addr_filt`=1, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is stored. With `cfg_addr_filt`=0, both kinds are stored.
- R4: `ferr` is 1 when the frame shown at the outputs had a 0 stop bit, and 0 for a frame whose stop bit was 1.
- R5: The start bit is sampled again half a bit after it was first seen. If the line has returned high by then, nothing is received.
- R6: `rx_idle` is 1 out of reset and whenever no frame is in progress, and 0 while a frame is being received.
- R7: The buffer holds two frames and delivers them in arrival order. A third frame that completes while both entries are full is dropped and sets `oerr`.
- R8: `oerr` stays 1, even after the buffer is read, until `cfg_rx_en` is 0.
- R9: A pulse on `wake_arm` sets `wake_armed`. While armed, no frame is received, and a falling line edge gives a one-cycle `wake_irq`. The next rising edge clears `wake_armed`.
- R10: While `cfg_en` is 0, the block is held in reset: the buffer is empty, the flags read 0, `rx_idle` reads 1 and the wake monitor is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial receive line, idles high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_en | input | 1 | Port enable; 0 holds the block in reset |
| cfg_nine | input | 1 | 1 selects nine-bit frames |
| cfg_rx_en | input | 1 | Receive enable; 0 also clears overrun |
| cfg_addr_filt | input | 1 | Keep only nine-bit frames whose ninth bit is 1 |
| wake_arm | input | 1 | Pulse that arms the wake monitor |
| rd_pop | input | 1 | Removes the frame at the head of the buffer |
| rd_data | output | 8 | Head frame data byte |
| rd_bit9 | output | 1 | Head frame ninth bit |
| ferr | output | 1 | Head frame had a bad stop bit |
| oerr | output | 1 | Sticky overrun flag |
| data_ready | output | 1 | Buffer is not empty |
| rx_idle | output | 1 | No frame in progress |
| wake_irq | output | 1 | One-cycle wake interrupt |
| wake_armed | output | 1 | Wake monitor armed |

## Verification
A frame enters the buffer on the tick that samples the middle of its stop bit. That is eight ticks into the stop bit, plus two cycles of input synchronisation. `data_ready` and the head outputs are therefore due before the stop bit ends. The bench leaves a quarter bit of idle line after each frame before it compares the scoreboard. The wake interrupt follows a line edge by three clocks (two synchroniser stages and the pulse register), so the bench counts pulses continuously instead of sampling in one cycle. All outputs are sampled on the falling clock edge, away from the edge where they change.

// File: rtl/uart_rx_addr.sv
module uart_rx_addr #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic       cfg_en,
  input  logic       cfg_nine,
  input  logic       cfg_rx_en,
  input  logic       cfg_addr_filt,
  input  logic       wake_arm,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       ferr,
  output logic       oerr,
  output logic       data_ready,
  output logic       rx_idle,
  output logic       wake_irq,
  output logic       wake_armed
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} st_t;

  logic [1:0]    sync;
  logic          rx_s, rx_prev;
  st_t           st;
  logic [CW-1:0] tcnt;
  logic [3:0]    bidx;
  logic [8:0]    shf;
  logic [9:0]    mem [2];
  logic          head;
  logic [1:0]    cnt;
  logic          oerr_q, armed, seen_fall, irq_q;

  assign rx_s = sync[1];

  wire       run      = cfg_en & cfg_rx_en & ~armed & ~wake_arm;
  wire [3:0] last_bit = cfg_nine ? 4'd8 : 4'd7;
  wire       done     = (st == S_STOP) & tick16 & (tcnt == LAST);
  wire       accept   = ~(cfg_nine & cfg_addr_filt) | shf[8];
  wire       pop      = rd_pop & (cnt != 2'd0);
  wire [1:0] cnt_ap   = cnt - {1'b0, pop};
  wire       head_ap  = head ^ pop;
  wire       room     = cnt_ap != 2'd2;
  wire       push     = done & accept & room;
  wire       slot     = head_ap ^ cnt_ap[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b1;
    end else begin
      sync    <= {sync[0], rx_line};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0; shf <= '0;
    end else if (!run) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (tick16 && !rx_s) begin
            st <= S_START; tcnt <= '0; shf <= '0;
          end
        S_START:
          if (tick16) begin
            if (tcnt == MID) begin
              tcnt <= '0; bidx <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
        S_DATA:
          if (tick16) begin
            if (tcnt == LAST) begin
              tcnt      <= '0;
              shf[bidx] <= rx_s;
              if (bidx == last_bit) st <= S_STOP;
              else bidx <= bidx + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
        S_STOP:
          if (tick16) begin
            if (tcnt == LAST) begin
              tcnt <= '0;
              st   <= rx_s ? S_IDLE : S_HOLD;
            end else tcnt <= tcnt + 1'b1;
          end
        S_HOLD:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= 1'b0; cnt <= '0; oerr_q <= 1'b0;
      mem[0] <= '0; mem[1] <= '0;
    end else if (!cfg_en) begin
      head <= 1'b0; cnt <= '0; oerr_q <= 1'b0;
    end else begin
      head <= head_ap;
      cnt  <= cnt_ap + {1'b0, push};
      if (push) mem[slot] <= {~rx_s, cfg_nine & shf[8], shf[7:0]};
      if (!cfg_rx_en) oerr_q <= 1'b0;
      else if (done && accept && !room) oerr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; seen_fall <= 1'b0; irq_q <= 1'b0;
    end else if (!cfg_en) begin
      armed <= 1'b0; seen_fall <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wake_arm) begin
        armed <= 1'b1; seen_fall <= 1'b0;
      end else if (armed) begin
        if (rx_prev && !rx_s) begin
          irq_q <= 1'b1; seen_fall <= 1'b1;
        end
        if (seen_fall && !rx_prev && rx_s) armed <= 1'b0;
      end
    end
  end

  assign data_ready = cnt != 2'd0;
  assign rd_data    = mem[head][7:0];
  assign rd_bit9    = mem[head][8];
  assign ferr       = data_ready & mem[head][9];
  assign oerr       = oerr_q;
  assign rx_idle    = st == S_IDLE;
  assign wake_irq   = irq_q;
  assign wake_armed = armed;
endmodule

module uart_rx_addr_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_rx_en,
  input logic data_ready,
  input logic oerr,
  input logic ferr,
  input logic rx_idle,
  input logic wake_irq,
  input logic wake_armed
);
  // R4
  ferr_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |-> data_ready);
  // R7
  oerr_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> $past(data_ready));
  // R8
  oerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oerr) |-> !$past(cfg_en && cfg_rx_en));
  // R9
  wake_irq_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(wake_armed));
  // R9
  armed_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wake_armed) |-> rx_idle);
  // R10
  port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_en) |-> (rx_idle && !data_ready && !oerr && !wake_armed));
endmodule

bind uart_rx_addr uart_rx_addr_chk u_chk (.*);

// File: tb/sim_uart_rx_addr.sv
`timescale 1ns/1ps
module sim_uart_rx_addr;
  localparam int BITCLK = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_line = 1'b1, cfg_en = 1'b1, cfg_nine = 1'b0, cfg_rx_en = 1'b1;
  logic cfg_addr_filt = 1'b0, wake_arm = 1'b0, mon_pop = 1'b0, man_pop = 1'b0;
  logic [1:0] tdiv = '0;
  logic tick16;
  logic [7:0] rd_data;
  logic rd_bit9, ferr, oerr, data_ready, rx_idle, wake_irq, wake_armed;
  logic mon_on = 1'b1;
  int tests = 0, fails = 0, irq_cnt = 0;
  logic [9:0] q [$];

  always #5 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = tdiv == 2'd3;
  always_ff @(posedge clk) if (wake_irq) irq_cnt <= irq_cnt + 1;

  uart_rx_addr u0 (.clk, .rst_n, .rx_line, .tick16, .cfg_en, .cfg_nine, .cfg_rx_en,
    .cfg_addr_filt, .wake_arm, .rd_pop(mon_pop | man_pop), .rd_data, .rd_bit9, .ferr,
    .oerr, .data_ready, .rx_idle, .wake_irq, .wake_armed);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mon_pop <= 1'b0;
    if (mon_on && data_ready && !mon_pop) begin
      if (q.size() == 0) chk(1'b0, "R3 unexpected frame", {ferr, rd_bit9, rd_data}, 0);
      else begin
        logic [9:0] e;
        e = q.pop_front();
        chk({ferr, rd_bit9, rd_data} == e, "R1/R2/R4 frame", {ferr, rd_bit9, rd_data}, e);
      end
      mon_pop <= 1'b1;
    end
  end

  task automatic send(input logic [8:0] d, input logic stop_ok, input logic exp);
    if (exp) q.push_back({~stop_ok, cfg_nine & d[8], d[7:0]});
    rx_line = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < (cfg_nine ? 9 : 8); i++) begin
      rx_line = d[i];
      repeat (BITCLK / 2) @(negedge clk);
      if (i == 2) chk(rx_idle == 1'b0, "R6 busy", rx_idle, 0);
      repeat (BITCLK / 2) @(negedge clk);
    end
    rx_line = stop_ok;
    repeat (BITCLK) @(negedge clk);
    rx_line = 1'b1;
    repeat (BITCLK / 4) @(negedge clk);
  endtask

  task automatic man_read(input logic [7:0] e, input string req);
    chk(data_ready && rd_data == e, req, rd_data, e);
    man_pop = 1'b1; @(negedge clk); man_pop = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 R10 reset state
    chk(rx_idle, "R6 reset idle", rx_idle, 1);
    chk(!data_ready && !oerr && !ferr && !wake_armed, "R10 reset flags",
        {data_ready, oerr, ferr, wake_armed}, 0);
    repeat (20) @(negedge clk);

    // R1 eight-bit frames
    send(9'h0A5, 1'b1, 1'b1);
    send(9'h03C, 1'b1, 1'b1);
    // R2 nine-bit, no filter: both kinds kept
    cfg_nine = 1'b1;
    send(9'h155, 1'b1, 1'b1);
    send(9'h0F0, 1'b1, 1'b1);
    // R3 filter: ninth bit 0 dropped, 1 kept
    cfg_addr_filt = 1'b1;
    send(9'h077, 1'b1, 1'b0);
    send(9'h1C3, 1'b1, 1'b1);
    cfg_addr_filt = 1'b0; cfg_nine = 1'b0;
    // R4 bad stop bit then good frame
    send(9'h05A, 1'b0, 1'b1);
    send(9'h081, 1'b1, 1'b1);
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);

    // R5 short low pulse is ignored
    rx_line = 1'b0; repeat (8) @(negedge clk); rx_line = 1'b1;
    repeat (BITCLK * 2) @(negedge clk);
    chk(rx_idle, "R5 glitch idle", rx_idle, 1);
    chk(!data_ready, "R5 glitch no data", data_ready, 0);

    // R7 R8 overrun
    mon_on = 1'b0;
    send(9'h011, 1'b1, 1'b0);
    send(9'h022, 1'b1, 1'b0);
    chk(!oerr, "R7 two frames fit", oerr, 0);
    send(9'h033, 1'b1, 1'b0);
    chk(oerr, "R7 overrun set", oerr, 1);
    man_read(8'h11, "R7 first kept");
    man_read(8'h22, "R7 second kept");
    chk(!data_ready, "R7 third dropped", data_ready, 0);
    chk(oerr, "R8 oerr sticky", oerr, 1);
    cfg_rx_en = 1'b0; repeat (2) @(negedge clk);
    chk(!oerr, "R8 cleared by rx disable", oerr, 1'b0);
    cfg_rx_en = 1'b1; repeat (2) @(negedge clk);

    // R9 wake monitor
    wake_arm = 1'b1; @(negedge clk); wake_arm = 1'b0; @(negedge clk);
    chk(wake_armed, "R9 armed", wake_armed, 1);
    rx_line = 1'b0; repeat (BITCLK * 12) @(negedge clk);
    chk(irq_cnt == 1, "R9 one irq", irq_cnt, 1);
    chk(wake_armed && rx_idle && !data_ready, "R9 no rx while armed",
        {wake_armed, rx_idle, data_ready}, 3'b110);
    rx_line = 1'b1; repeat (6) @(negedge clk);
    chk(!wake_armed, "R9 disarm on rise", wake_armed, 0);
    rx_line = 1'b0; repeat (8) @(negedge clk); rx_line = 1'b1;
    repeat (BITCLK * 2) @(negedge clk);
    chk(irq_cnt == 1, "R9 no irq after disarm", irq_cnt, 1);

    // R10 port disable
    send(9'h044, 1'b1, 1'b0);
    chk(data_ready, "R10 data before disable", data_ready, 1);
    wake_arm = 1'b1; @(negedge clk); wake_arm = 1'b0;
    cfg_en = 1'b0; repeat (2) @(negedge clk);
    chk(!data_ready && rx_idle && !wake_armed, "R10 held in reset",
        {data_ready, rx_idle, wake_armed}, 3'b010);
    cfg_en = 1'b1; mon_on = 1'b1; repeat (2) @(negedge clk);
    send(9'h0EE, 1'b1, 1'b1);
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R1 after re-enable", q.size(), 0);
    finish_run();
  end
endmodule